// File: doc/BRIEF.md
# Configurable CRC and Checksum Engine

A register-mapped engine that folds words written one at a time by software into a running CRC or a 16-bit ones-complement checksum. Each write to the data register is absorbed in the clock edge that takes it. Software first programs a control register. It picks the algorithm, the source of the starting value and the input width. It also enables byte and halfword swapping and per-byte bit reversal of the input, and per-byte bit reversal and inversion of the result.

The seed register gives the starting value and is overwritten with every raw intermediate value. Software can therefore save a partial computation and restore it later. The result register is read-only and returns the post-processed view of the seed. All register reads are combinational on a separate read address, so software can poll a result in the cycle after a write.

Top module: `crc_cksum_engine`

## Requirements
- R1: After reset the control, seed and result registers all read 0.
- R2: The control register sits at offset 0xC00. Only bits 14:12, 9:7 and 5:0 are writable, and the others read 0. The seed register at 0xC10 reads back what was last written or computed. The data register at 0xC14 and all unmapped offsets read 0. The result register is at 0xC18.
- R3: Type codes 0000 and 0001 run an MSB-first CRC with the 16-bit polynomials 0x8005 and 0x1021. Only the low 16 bits of the state and of the result are used, and the upper 16 bits read 0.
- R4: Type codes 0010 and 0011 run an MSB-first CRC with the 32-bit polynomials 0x04C11DB7 and 0x1EDC6F41. The first bit absorbed is bit 31 of the transformed word, or bit 7 of the byte in 8-bit mode.
- R5: Type code 1000 adds the input to the low 16 bits of the state in ones-complement arithmetic. A 32-bit word adds as its two halfwords and an 8-bit input adds as one zero-extended value. Every end-around carry is folded back into the sum.
- R6: The control field at bits 14:13 picks the starting value of a data write: 00 uses the seed, 10 uses all zeros and 11 uses all ones. An accepted data write returns the field to 00.
- R7: With control bit 12 set, only bits 7:0 of a data write are absorbed and the byte-swap controls have no effect.
- R8: In 32-bit mode, control bit 4 swaps the bytes inside each halfword and control bit 5 then swaps the halfwords. Control bit 7 then reverses the bit order inside every byte before the CRC or checksum update.
- R9: The result register is the seed, byte-bit-reversed when control bit 8 is set, then inverted when control bit 9 is set. The seed itself stays raw.
- R10: With a type code outside 0000 to 0011 and 1000, or with 14:13 = 01, a data write changes neither the seed nor the control register.
- R11: A write to the seed register replaces the running value, so a saved value written back resumes the computation exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write byte offset |
| wrData | input | 32 | Write data |
| rdAddr | input | ADDR_W | Read byte offset |
| rdData | output | 32 | Combinational read data |

## Verification
Four things are checked on every cycle: a seed write lands exactly, a control write keeps only the writable bits, an accepted data write clears the init field, and a rejected data write leaves the seed and control untouched. A 16-bit type also has to leave the upper seed half clear. The arithmetic itself can only be shown by the bench scenarios, which compare against a byte-wise reference model and against published check values. These cover the polynomials, the carry folding of the checksum, the order of swaps and reversal, and the order of output reversal and inversion.

// File: rtl/crc_cksum_pkg.sv
package crc_cksum_pkg;

  localparam int DATA_W = 32;
  localparam int CTRL_W = 16;

  localparam logic [11:0] OFF_CTRL   = 12'hC00;
  localparam logic [11:0] OFF_SEED   = 12'hC10;
  localparam logic [11:0] OFF_DATA   = 12'hC14;
  localparam logic [11:0] OFF_RESULT = 12'hC18;

  localparam logic [CTRL_W-1:0] CTRL_MASK = 16'h73BF;

  localparam int B_SWAPB  = 4;
  localparam int B_SWAPH  = 5;
  localparam int B_INREV  = 7;
  localparam int B_OUTREV = 8;
  localparam int B_OUTINV = 9;
  localparam int B_SIZE8  = 12;
  localparam int B_INITLO = 13;

  typedef enum logic [1:0] {
    START_SEED = 2'b00,
    START_RSVD = 2'b01,
    START_ZERO = 2'b10,
    START_ONES = 2'b11
  } startSel_e;

  typedef struct packed {
    logic      seedLoad;
    logic      absorb;
    startSel_e startSel;
  } strobes_t;

  function automatic logic typeValid(input logic [3:0] t);
    return (t == 4'h0) || (t == 4'h1) || (t == 4'h2) || (t == 4'h3) || (t == 4'h8);
  endfunction

  function automatic logic [DATA_W-1:0] polyOf(input logic [3:0] t);
    case (t)
      4'h0:    return 32'h0000_8005;
      4'h1:    return 32'h0000_1021;
      4'h2:    return 32'h04C1_1DB7;
      default: return 32'h1EDC_6F41;
    endcase
  endfunction

endpackage

// File: rtl/crc_cksum_ctrl.sv
module crc_cksum_ctrl
  import crc_cksum_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [CTRL_W-1:0] ctrlQ,
  output strobes_t          strobes
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(OFF_SEED);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);

  logic      ctrlWr, dataWr, accept;
  startSel_e initSel;

  assign initSel = startSel_e'(ctrlQ[B_INITLO+1:B_INITLO]);
  assign ctrlWr  = wrEn && (wrAddr == A_CTRL);
  assign dataWr  = wrEn && (wrAddr == A_DATA);
  assign accept  = dataWr && typeValid(ctrlQ[3:0]) && (initSel != START_RSVD);

  assign strobes.seedLoad = wrEn && (wrAddr == A_SEED);
  assign strobes.absorb   = accept;
  assign strobes.startSel = initSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWr) begin
      ctrlQ <= wrData[CTRL_W-1:0] & CTRL_MASK;
    end else if (accept) begin
      ctrlQ[B_INITLO+1:B_INITLO] <= 2'b00;
    end
  end

endmodule

// File: rtl/crc_cksum_datapath.sv
module crc_cksum_datapath
  import crc_cksum_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [CTRL_W-1:0] ctrlQ,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] seedQ,
  output logic [DATA_W-1:0] resultQ
);

  localparam int NBYTES = DATA_W / 8;

  logic [3:0]        opType;
  logic              isCksum, isNarrow, size8;
  logic [DATA_W-1:0] swapped, reordered, revIn, aligned, startVal, crcNext;
  logic [DATA_W-1:0] nextVal, revOut, postVal;
  logic [17:0]       sumRaw;
  logic [16:0]       sumFold1;
  logic [15:0]       sumFinal;

  assign opType   = ctrlQ[3:0];
  assign isCksum  = (opType == 4'h8);
  assign isNarrow = isCksum || (opType == 4'h0) || (opType == 4'h1);
  assign size8    = ctrlQ[B_SIZE8];

  // input: swap within halfwords, then swap halfwords
  assign swapped   = ctrlQ[B_SWAPB] ? {wrData[23:16], wrData[31:24], wrData[7:0], wrData[15:8]}
                                    : wrData;
  assign reordered = size8 ? {24'b0, wrData[7:0]}
                           : (ctrlQ[B_SWAPH] ? {swapped[15:0], swapped[31:16]} : swapped);

  // per-byte bit reversal of input and of result
  for (genvar b = 0; b < NBYTES; b++) begin : g_byteRev
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign revIn[8*b+k]  = ctrlQ[B_INREV]  ? reordered[8*b+7-k] : reordered[8*b+k];
      assign revOut[8*b+k] = ctrlQ[B_OUTREV] ? seedQ[8*b+7-k]     : seedQ[8*b+k];
    end
  end

  assign aligned = size8 ? {revIn[7:0], 24'b0} : revIn;

  always_comb begin
    case (strobes.startSel)
      START_ZERO: startVal = '0;
      START_ONES: startVal = '1;
      default:    startVal = seedQ;
    endcase
    if (isNarrow) startVal[31:16] = '0;
  end

  // bit-serial CRC, unrolled over one word
  always_comb begin
    logic [DATA_W-1:0] st;
    logic              fb;
    st = startVal;
    for (int i = 0; i < DATA_W; i++) begin
      if (!size8 || i < 8) begin
        fb = (isNarrow ? st[15] : st[31]) ^ aligned[DATA_W-1-i];
        st = (st << 1) ^ (fb ? polyOf(opType) : '0);
        if (isNarrow) st[31:16] = '0;
      end
    end
    crcNext = st;
  end

  // ones-complement sum with end-around carry folding
  assign sumRaw   = {2'b0, startVal[15:0]}
                  + (size8 ? {10'b0, revIn[7:0]} : {2'b0, revIn[31:16]})
                  + (size8 ? 18'd0 : {2'b0, revIn[15:0]});
  assign sumFold1 = {1'b0, sumRaw[15:0]} + {15'b0, sumRaw[17:16]};
  assign sumFinal = sumFold1[15:0] + {15'b0, sumFold1[16]};

  assign nextVal = isCksum ? {16'b0, sumFinal} : crcNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seedQ <= '0;
    end else if (strobes.seedLoad) begin
      seedQ <= wrData;
    end else if (strobes.absorb) begin
      seedQ <= nextVal;
    end
  end

  always_comb begin
    postVal = ctrlQ[B_OUTINV] ? ~revOut : revOut;
    if (isNarrow) postVal[31:16] = '0;
  end
  assign resultQ = postVal;

endmodule

// File: rtl/crc_cksum_engine.sv
module crc_cksum_engine
  import crc_cksum_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData
);

  logic [CTRL_W-1:0] ctrlQ;
  logic [DATA_W-1:0] seedQ, resultQ;
  strobes_t          strobes;

  crc_cksum_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ctrlQ(ctrlQ), .strobes(strobes)
  );

  crc_cksum_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ctrlQ(ctrlQ), .wrData(wrData),
    .seedQ(seedQ), .resultQ(resultQ)
  );

  always_comb begin
    if (rdAddr == ADDR_W'(OFF_CTRL))        rdData = {16'b0, ctrlQ};
    else if (rdAddr == ADDR_W'(OFF_SEED))   rdData = seedQ;
    else if (rdAddr == ADDR_W'(OFF_RESULT)) rdData = resultQ;
    else                                    rdData = '0;
  end

endmodule

// File: rtl/crc_cksum_checker.sv
module crc_cksum_checker
  import crc_cksum_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [31:0]       wrData,
  input logic [CTRL_W-1:0] ctrlQ,
  input logic [DATA_W-1:0] seedQ
);

  logic dataWr, goodCfg;
  assign dataWr  = wrEn && (wrAddr == ADDR_W'(OFF_DATA));
  assign goodCfg = typeValid(ctrlQ[3:0]) && (ctrlQ[14:13] != 2'b01);

  assert_seed_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(OFF_SEED)) |=> (seedQ == $past(wrData)));

  assert_ctrl_mask_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(OFF_CTRL)) |=> (ctrlQ == ($past(wrData[15:0]) & 16'h73BF)));

  assert_init_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && goodCfg) |=> (ctrlQ[14:13] == 2'b00));

  assert_reject_seed_R10: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !goodCfg) |=> ($stable(seedQ) && $stable(ctrlQ)));

  assert_narrow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && goodCfg && (ctrlQ[3:0] == 4'h0 || ctrlQ[3:0] == 4'h1))
      |=> (seedQ[31:16] == 16'h0));

  assert_cksum_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && goodCfg && ctrlQ[3:0] == 4'h8) |=> (seedQ[31:16] == 16'h0));

endmodule

bind crc_cksum_engine crc_cksum_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_crc_cksum_engine.sv
module tb_crc_cksum_engine;

  logic        clk = 0;
  logic        rstN = 0;
  logic        wrEn = 0;
  logic [11:0] wrAddr = 0;
  logic [31:0] wrData = 0;
  logic [11:0] rdAddr = 0;
  logic [31:0] rdData;

  int nChecks = 0;
  int nErrors = 0;

  // reference state
  logic [15:0] mCtrl = 0;
  logic [31:0] mSeed = 0;

  always #5 clk = ~clk;

  crc_cksum_engine dut (.*);

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = v[7-k];
    return r;
  endfunction

  function automatic logic [31:0] mResult();
    logic [31:0] v;
    int t;
    t = mCtrl[3:0];
    v = mSeed;
    if (mCtrl[8]) for (int b = 0; b < 4; b++) v[8*b +: 8] = rev8(v[8*b +: 8]);
    if (mCtrl[9]) v = ~v;
    if (t == 0 || t == 1 || t == 8) v[31:16] = 0;
    return v;
  endfunction

  // byte-at-a-time model
  function automatic logic [31:0] crcByte(input logic [31:0] s, input logic [7:0] by, input int t);
    logic [31:0] poly;
    logic [31:0] st;
    poly = (t == 0) ? 32'h8005 : (t == 1) ? 32'h1021 : (t == 2) ? 32'h04C11DB7 : 32'h1EDC6F41;
    st = s;
    if (t < 2) begin
      st[15:8] = st[15:8] ^ by;
      for (int k = 0; k < 8; k++) st[15:0] = st[15] ? ((st[15:0] << 1) ^ poly[15:0]) : (st[15:0] << 1);
      st[31:16] = 0;
    end else begin
      st[31:24] = st[31:24] ^ by;
      for (int k = 0; k < 8; k++) st = st[31] ? ((st << 1) ^ poly) : (st << 1);
    end
    return st;
  endfunction

  task automatic mData(input logic [31:0] d);
    int t, n;
    logic [7:0] by[4];
    logic [7:0] tmp;
    logic [31:0] s;
    int sum;
    t = mCtrl[3:0];
    if (!(t <= 3 || t == 8) || mCtrl[14:13] == 2'b01) return;
    case (mCtrl[14:13])
      2'b10:   s = 0;
      2'b11:   s = 32'hFFFFFFFF;
      default: s = mSeed;
    endcase
    if (t == 0 || t == 1 || t == 8) s[31:16] = 0;
    if (mCtrl[12]) begin
      n = 1; by[0] = d[7:0];
    end else begin
      n = 4;
      for (int i = 0; i < 4; i++) by[i] = d[31-8*i -: 8];
      if (mCtrl[4]) begin
        tmp = by[0]; by[0] = by[1]; by[1] = tmp;
        tmp = by[2]; by[2] = by[3]; by[3] = tmp;
      end
      if (mCtrl[5]) begin
        tmp = by[0]; by[0] = by[2]; by[2] = tmp;
        tmp = by[1]; by[1] = by[3]; by[3] = tmp;
      end
    end
    if (mCtrl[7]) for (int i = 0; i < n; i++) by[i] = rev8(by[i]);
    if (t == 8) begin
      sum = s[15:0];
      if (n == 1) sum += by[0];
      else sum += {by[0], by[1]} + {by[2], by[3]};
      while (sum > 16'hFFFF) sum = (sum & 16'hFFFF) + (sum >> 16);
      s = sum;
    end else begin
      for (int i = 0; i < n; i++) s = crcByte(s, by[i], t);
    end
    mSeed = s;
    mCtrl[14:13] = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
    if (a == 12'hC00) mCtrl = d[15:0] & 16'h73BF;
    else if (a == 12'hC10) mSeed = d;
    else if (a == 12'hC14) mData(d);
  endtask

  task automatic chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    rdAddr = a;
    #1;
    nChecks++;
    if (rdData !== exp) begin
      nErrors++;
      $display("FAIL %s: offset %h got %h expected %h", tag, a, rdData, exp);
    end
  endtask

  task automatic chkAll(input string tag);
    chk(12'hC00, {16'b0, mCtrl}, tag);
    chk(12'hC10, mSeed, tag);
    chk(12'hC18, mResult(), tag);
  endtask

  initial begin
    #1_000_000;
    nErrors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] saved;
    logic [31:0] ck;
    repeat (2) @(negedge clk);
    chkAll("R1 reset");
    rstN = 1;
    @(negedge clk);
    chkAll("R1 after reset release");

    // R2 register map and writable bits
    wr(12'hC00, 32'hFFFF_FFFF);
    chk(12'hC00, 32'h0000_73BF, "R2 ctrl mask");
    wr(12'hC10, 32'hDEAD_BEEF);
    chk(12'hC10, 32'hDEAD_BEEF, "R2 seed readback");
    chk(12'hC14, 32'h0, "R2 data reads zero");
    chk(12'hC04, 32'h0, "R2 unmapped reads zero");

    // R3 0x1021, all-ones start, bytes "123456789" -> 0x29B1 (R7 byte mode)
    wr(12'hC00, 32'h0000_7001);
    for (int i = 0; i < 9; i++) begin
      wr(12'hC14, 32'hABCD_EF00 | (32'h31 + i));
      chkAll("R7 byte stream 0x1021");
    end
    chk(12'hC10, 32'h0000_29B1, "R3 0x1021 check value");
    chk(12'hC00, 32'h0000_1001, "R6 init field cleared");

    // R3 0x8005, zero start -> 0xFEE8
    wr(12'hC00, 32'h0000_5000);
    for (int i = 0; i < 9; i++) wr(12'hC14, 32'h31 + i);
    chk(12'hC10, 32'h0000_FEE8, "R3 0x8005 check value");
    chkAll("R3 0x8005 model");

    // R4 0x04C11DB7, ones start, two words then a byte -> 0x0376E6E7
    wr(12'hC00, 32'h0000_6002);
    wr(12'hC14, 32'h3132_3334);
    wr(12'hC14, 32'h3536_3738);
    wr(12'hC00, 32'h0000_1002);
    wr(12'hC14, 32'h0000_0039);
    chk(12'hC10, 32'h0376_E6E7, "R4 0x04C11DB7 check value");
    chkAll("R4 model");

    // R8 swaps and input reversal over each combination, both 32-bit types
    for (int m = 0; m < 8; m++) begin
      logic [31:0] cfg;
      cfg = 32'h0000_6002 | (m[0] ? 32'h10 : 0) | (m[1] ? 32'h20 : 0) | (m[2] ? 32'h80 : 0);
      if (m >= 4) cfg[0] = 1;
      wr(12'hC00, cfg);
      wr(12'hC14, 32'h1234_5678 ^ (m * 32'h0101_1011));
      wr(12'hC14, 32'h8000_0001 + m);
      chkAll("R8 swap/reverse order");
    end

    // R5 checksum carry folding
    wr(12'hC00, 32'h0000_4008);
    wr(12'hC14, 32'hFFFF_0002);
    chk(12'hC10, 32'h0000_0002, "R5 end-around carry");
    wr(12'hC14, 32'hFFFF_FFFF);
    chkAll("R5 checksum word");
    wr(12'hC00, 32'h0000_1008);
    wr(12'hC14, 32'h1234_56FE);
    chkAll("R5 checksum byte");
    wr(12'hC00, 32'h0000_00B8);
    wr(12'hC14, 32'hA5C3_0F81);
    chkAll("R5 checksum with swaps");

    // R9 output reverse then invert; seed raw
    wr(12'hC00, 32'h0000_6003);
    wr(12'hC14, 32'hCAFE_F00D);
    ck = mSeed;
    wr(12'hC00, 32'h0000_0103);
    chkAll("R9 output reverse");
    wr(12'hC00, 32'h0000_0303);
    chkAll("R9 reverse and invert");
    chk(12'hC10, ck, "R9 seed stays raw");
    wr(12'hC00, 32'h0000_0301);
    chkAll("R9 narrow result");

    // R10 reserved type and init 01 have no effect
    wr(12'hC00, 32'h0000_6005);
    saved = mSeed;
    wr(12'hC14, 32'h1111_2222);
    chk(12'hC10, saved, "R10 reserved type keeps seed");
    chk(12'hC00, 32'h0000_6005, "R10 reserved type keeps init");
    wr(12'hC00, 32'h0000_2002);
    wr(12'hC14, 32'h3333_4444);
    chk(12'hC10, saved, "R10 init 01 keeps seed");
    chk(12'hC00, 32'h0000_2002, "R10 init 01 keeps ctrl");

    // R11 save and restore
    wr(12'hC00, 32'h0000_6003);
    wr(12'hC14, 32'h0BAD_CAFE);
    saved = mSeed;
    wr(12'hC14, 32'h5555_AAAA);
    ck = mSeed;
    wr(12'hC10, 32'h0);
    wr(12'hC14, 32'h7777_7777);
    chkAll("R11 interrupted stream");
    wr(12'hC10, saved);
    wr(12'hC14, 32'h5555_AAAA);
    chk(12'hC10, ck, "R11 restored stream");

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule